// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational 16-bit binary adder. Two operands and a carry-in arrive on the inputs, and the 16-bit sum and the carry-out leave on the outputs in the same cycle. No register sits anywhere in the path.

The operands are split into four 4-bit slices. Inside each slice, every bit forms a generate term (both operand bits set) and a propagate term (either operand bit set). Each carry inside the slice is then written directly as a sum of products of those terms and the slice carry-in, so carries never ripple from bit to bit. Each slice also reduces its bits to one slice-wide propagate and one slice-wide generate.

A second lookahead unit of the same form takes the four slice-wide pairs and the adder carry-in and produces every slice carry-in and the final carry-out directly. A carry therefore crosses at most the two lookahead levels between any input and any output.

Top module: `carryLookaheadAdder`

## Requirements
- R1: `sumOut` equals the low 16 bits of `opA + opB + carryIn`, unsigned, for every input combination.
- R2: `carryOut` equals bit 16 of the 17-bit unsigned value `opA + opB + carryIn`.
- R3: A bit position where both operand bits are 1 produces a carry into the next position whatever the incoming carry (for example 0x0001 + 0x0001 gives 0x0002).
- R4: A bit position where exactly one operand bit is 1 passes its incoming carry onward, so a carry-in of 1 runs through an all-propagate operand pair to the carry-out (0xFFFF + 0x0000 + 1 gives sum 0x0000, carry-out 1).
- R5: A carry leaving any 4-bit slice (bits 3, 7, 11 to the next slice) enters the next slice, and the carry leaving bit 15 appears on `carryOut`.
- R6: With both operands zero, the outputs are `sumOut` equal to `carryIn` and `carryOut` 0.
- R7: The carry computed into each slice by the second lookahead level equals the carry-out that the previous slice derives on its own from its bits and its carry-in.
- R8: A slice whose bits all propagate and do not generate passes its carry-in straight to its carry-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand, unsigned |
| opB | input | 16 | Second operand, unsigned |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 16 | Sum bits |
| carryOut | output | 1 | Carry out of bit 15 |

## Verification
The hardest case to reach from the ports is a carry that is born in one slice and must cross one or more whole slices that only propagate, since random operands rarely line up long propagate chains across slice boundaries. The stimulus reaches it in two ways: every 4-bit operand pair with both carry-in values is placed into each slice position while the other slices are filled with propagate patterns (one operand all ones, the other zero), and directed cases start a single generate at a boundary bit and let it run through the remaining slices to the carry-out. Random full-width pairs then cover the mixed cases.

// File: rtl/claPkg.sv
package claPkg;
  localparam int unsigned DEF_WIDTH   = 16;
  localparam int unsigned DEF_GROUP_W = 4;

  typedef struct packed {
    logic prop;
    logic gen;
  } pgPair_t;
endpackage

// File: rtl/claLookahead.sv
// Flattened lookahead unit: every carry is a single sum of products of the
// generate/propagate terms and the incoming carry. Used at both levels.
module claLookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] genIn,
  input  logic [N-1:0] propIn,
  input  logic         carryIn,
  output logic [N:1]   carryOut,
  output logic         grpProp,
  output logic         grpGen
);
  logic [N:1] carryV;
  logic       genAcc;

  always_comb begin
    for (int k = 1; k <= N; k++) begin
      logic acc;
      logic prod;
      acc = 1'b0;
      for (int j = 0; j < k; j++) begin
        prod = genIn[j];
        for (int m = j + 1; m < k; m++) prod = prod & propIn[m];
        acc = acc | prod;
      end
      prod = carryIn;
      for (int m = 0; m < k; m++) prod = prod & propIn[m];
      carryV[k] = acc | prod;
    end
  end

  always_comb begin
    genAcc = 1'b0;
    for (int j = 0; j < N; j++) begin
      logic prod;
      prod = genIn[j];
      for (int m = j + 1; m < N; m++) prod = prod & propIn[m];
      genAcc = genAcc | prod;
    end
  end

  assign carryOut = carryV;
  assign grpProp  = &propIn;
  assign grpGen   = genAcc;

  // R8: all propagating and none generating means carry passes straight through
  always_comb begin
    if ((&propIn) && (genIn == '0))
      assert_pass_through_R8: assert (carryV[N] == carryIn);
  end
endmodule

// File: rtl/claGroup.sv
module claGroup #(
  parameter int unsigned GROUP_W = claPkg::DEF_GROUP_W
) (
  input  logic [GROUP_W-1:0] bitsA,
  input  logic [GROUP_W-1:0] bitsB,
  input  logic               groupCin,
  output logic [GROUP_W-1:0] groupSum,
  output claPkg::pgPair_t    groupPg,
  output logic               localCout
);
  logic [GROUP_W-1:0] bitGen;
  logic [GROUP_W-1:0] bitProp;
  logic [GROUP_W:0]   bitCarry;
  logic [GROUP_W:1]   laCarry;
  logic               pgProp;
  logic               pgGen;

  assign bitGen  = bitsA & bitsB;
  assign bitProp = bitsA | bitsB;

  claLookahead #(.N(GROUP_W)) la_i (
    .genIn   (bitGen),
    .propIn  (bitProp),
    .carryIn (groupCin),
    .carryOut(laCarry),
    .grpProp (pgProp),
    .grpGen  (pgGen)
  );

  assign bitCarry = {laCarry, groupCin};

  genvar i;
  generate
    for (i = 0; i < GROUP_W; i++) begin : g_sum
      assign groupSum[i] = bitsA[i] ^ bitsB[i] ^ bitCarry[i];
    end
  endgenerate

  assign groupPg.prop = pgProp;
  assign groupPg.gen  = pgGen;
  assign localCout    = laCarry[GROUP_W];

  // R3: a generating bit always produces a carry into the next position
  always_comb begin
    for (int i2 = 0; i2 < GROUP_W; i2++)
      if (bitsA[i2] && bitsB[i2])
        assert_bit_generate_R3: assert (bitCarry[i2+1]);
  end

  // R5: slice carry-out agrees with the slice summary terms
  always_comb begin
    assert_slice_summary_R5: assert (localCout == (pgGen | (pgProp & groupCin)));
  end
endmodule

// File: rtl/carryLookaheadAdder.sv
module carryLookaheadAdder #(
  parameter int unsigned WIDTH   = claPkg::DEF_WIDTH,
  parameter int unsigned GROUP_W = claPkg::DEF_GROUP_W
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  localparam int unsigned NUM_GROUPS = WIDTH / GROUP_W;

  claPkg::pgPair_t          groupPg [NUM_GROUPS];
  logic [NUM_GROUPS-1:0]    groupGen;
  logic [NUM_GROUPS-1:0]    groupProp;
  logic [NUM_GROUPS-1:0]    groupLocalCout;
  logic [NUM_GROUPS:1]      topCarry;
  logic [NUM_GROUPS-1:0]    groupCin;
  logic                     topProp;
  logic                     topGen;

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
      if (g == 0) begin : g_first
        assign groupCin[g] = carryIn;
      end else begin : g_rest
        assign groupCin[g] = topCarry[g];
      end

      claGroup #(.GROUP_W(GROUP_W)) grp_i (
        .bitsA    (opA[g*GROUP_W +: GROUP_W]),
        .bitsB    (opB[g*GROUP_W +: GROUP_W]),
        .groupCin (groupCin[g]),
        .groupSum (sumOut[g*GROUP_W +: GROUP_W]),
        .groupPg  (groupPg[g]),
        .localCout(groupLocalCout[g])
      );

      assign groupGen[g]  = groupPg[g].gen;
      assign groupProp[g] = groupPg[g].prop;
    end
  endgenerate

  claLookahead #(.N(NUM_GROUPS)) top_la_i (
    .genIn   (groupGen),
    .propIn  (groupProp),
    .carryIn (carryIn),
    .carryOut(topCarry),
    .grpProp (topProp),
    .grpGen  (topGen)
  );

  assign carryOut = topCarry[NUM_GROUPS];

  // R7: second-level carries match each slice's own carry-out
  always_comb begin
    for (int k = 0; k < NUM_GROUPS; k++)
      assert_level_agree_R7: assert (topCarry[k+1] == groupLocalCout[k]);
  end

  // R1, R2: outputs match unsigned addition
  always_comb begin
    assert_sum_value_R1: assert ({carryOut, sumOut} ==
      ({1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn}));
    assert_top_summary_R2: assert (carryOut == (topGen | (topProp & carryIn)));
  end
endmodule

// File: tb/carryLookaheadAdder_tb.sv
module carryLookaheadAdder_tb_top;
  logic        clk = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [15:0] sumOut;
  logic        carryOut;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  carryLookaheadAdder dut_i (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut)
  );

  task automatic applyCheck(input logic [15:0] a, input logic [15:0] b,
                            input logic ci, input string req);
    logic [16:0] expV;
    @(negedge clk);
    opA = a; opB = b; carryIn = ci;
    #1;
    expV = {1'b0, a} + {1'b0, b} + {16'd0, ci};
    total++;
    if ({carryOut, sumOut} !== expV) begin
      bad++;
      $display("FAIL %s: a=%h b=%h ci=%0d got cout=%0d sum=%h exp cout=%0d sum=%h",
               req, a, b, ci, carryOut, sumOut, expV[16], expV[15:0]);
    end
  endtask

  task automatic testZeroInputs();  // R6
    applyCheck(16'h0000, 16'h0000, 1'b0, "R6");
    applyCheck(16'h0000, 16'h0000, 1'b1, "R6");
  endtask

  task automatic testGenerate();  // R3
    applyCheck(16'h0001, 16'h0001, 1'b0, "R3");
    applyCheck(16'h0100, 16'h0100, 1'b0, "R3");
    applyCheck(16'h8000, 16'h8000, 1'b1, "R3");
  endtask

  task automatic testPropagateChain();  // R4
    applyCheck(16'hFFFF, 16'h0000, 1'b1, "R4");
    applyCheck(16'hAAAA, 16'h5555, 1'b1, "R4");
    applyCheck(16'h0F0F, 16'hF0F0, 1'b0, "R4");
  endtask

  task automatic testBoundaries();  // R5
    for (int k = 1; k < 4; k++) begin
      applyCheck(16'h1 << (4*k-1), 16'h1 << (4*k-1), 1'b0, "R5");
      applyCheck(16'h000F << (4*(k-1)), 16'h1 << (4*(k-1)), 1'b0, "R5");
    end
    applyCheck(16'h0008, 16'hFFF8, 1'b0, "R5");
    applyCheck(16'hFFFF, 16'hFFFF, 1'b1, "R5");
  endtask

  task automatic testSlices();  // R1, R2, R7, R8
    for (int pos = 0; pos < 4; pos++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int ci = 0; ci < 2; ci++) begin
            logic [15:0] fillA;
            fillA = 16'hFFFF & ~(16'hF << (4*pos));
            applyCheck(fillA | (16'(a) << (4*pos)), 16'(b) << (4*pos),
                       ci[0], "R7");
          end
  endtask

  task automatic testRandom();  // R1, R2
    for (int n = 0; n < 3000; n++)
      applyCheck(16'($urandom), 16'($urandom), 1'($urandom), "R1/R2");
  endtask

  initial begin
    fork
      begin
        testZeroInputs();
        testGenerate();
        testPropagateChain();
        testBoundaries();
        testSlices();
        testRandom();
        finished = 1;
      end
      begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
          total++; bad++;
          $display("FAIL watchdog: got timeout exp completion");
        end
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule